// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave side of a three-wire serial link. The link has a chip-enable line, a serial clock and one bidirectional data pin. While chip enable is high, the host shifts in a command byte, least significant bit first. The block then reads or writes one byte, or runs a burst, in one of two register spaces. The clock space has seven data registers plus a control register. The RAM space has 31 bytes. The block drives the data pin through an output-enable signal. Serial inputs are sampled in the system clock domain, and edges of the serial clock are found by comparing the pin with its value one system clock earlier.

A command byte has four fields: a valid marker, a space select, a five-bit register address and a direction. An address of all ones selects burst mode, which walks through the space from address 0. Burst writes to the clock space are held in a staging buffer. They reach the registers only when the eighth byte completes, so a partial update can never leave the time registers inconsistent. The control register carries a write-protect flag that guards everything except the control register itself.

Top module: `sio3_slave`

## Requirements
- R1: Command format. Bits are sampled on rising serial clock edges, least significant bit first. Bit 7 = 1 marks a valid command. Bit 6 = 1 selects RAM and 0 selects clock space. Bits 5:1 give the address. Bit 0 = 1 means read and 0 means write.
- R2: In a read, bit 0 of the data is driven on the first falling edge after the eighth command bit. The remaining bits follow on the next falling edges, one per edge, least significant first. The output enable is high while a bit is driven.
- R3: The data pin is released (output enable low) after every rising serial clock edge.
- R4: In a single write, the data byte is taken from the eight rising edges that follow the command. Any later cycles in the same transfer have no effect.
- R5: In a single read, extra cycles send the same byte again for as long as chip enable stays high.
- R6: Address 31 selects burst mode. Bytes run from address 0 and the address advances by one per byte. A burst read wraps to address 0 after the last byte of the space (byte 7 in clock space, byte 30 in RAM).
- R7: A clock-space burst write changes the clock and control registers only after all eight bytes have arrived. If chip enable falls before that, nothing changes.
- R8: The control register sits at clock address 7. Bit 7 is the write-protect flag, and bits 6:0 always read 0. While the flag is 1, writes to clock addresses 0 to 6 and to RAM are dropped. The control register can still be written. In a protected clock burst, only the control byte takes effect.
- R9: A RAM burst write stores each byte as soon as it completes, however many bytes are sent (31 at most).
- R10: When chip enable goes low, the transfer ends, the data pin is released and the next transfer starts with a new command.
- R11: Clock-space addresses 8 to 30 have no storage. They read 0x00 and writes to them are dropped.
- R12: A command with bit 7 = 0 is ignored until chip enable falls. No register changes and the pin stays released.
- R13: After reset, the data pin is released and all registers, including the write-protect flag, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable; high for the length of a transfer |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| sdio_i | input | 1 | Data pin, input side |
| sdio_o | output | 1 | Data pin, output side |
| sdio_oe_o | output | 1 | Data pin output enable |

## Verification
Each serial clock edge is detected on the first system clock edge where the pin differs from its registered copy. The output it causes is therefore registered one system clock later. This holds for a pin release after a rising edge, a new data bit after a falling edge, and a release after chip enable falls. The bench changes the serial inputs on falling system clock edges and marks its comparison window invalid at that moment. It opens the window again two system clocks later and then compares the pin and its enable with the reference model on every falling system clock edge until the next change. Writes are checked by reading the registers back, once the transfer that wrote them has finished.

// File: rtl/sio3_pkg.sv
package sio3_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] BURST_ADDR = '1;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_IDLE} phase_e;
endpackage

// File: rtl/sio3_link.sv
module sio3_link
  import sio3_pkg::*;
#(
  parameter int CLK_REGS  = 8,
  parameter int RAM_BYTES = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              wr_o,
  output logic              ram_o,
  output logic              burst_clk_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  input  logic [7:0]        rd_data_i
);
  localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'(CLK_REGS - 1);
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_BYTES - 1);

  phase_e            phase_q;
  logic              sclk_q;
  logic [2:0]        bit_q;
  logic [ADDR_W-1:0] byte_q, cmd_addr_q, last_byte;
  logic [6:0]        sr_q;
  logic              cmd_ram_q;
  logic              rise, fall, burst;
  logic [7:0]        shift_in;

  assign rise      = sclk_i & ~sclk_q;
  assign fall      = ~sclk_i & sclk_q;
  assign shift_in  = {sdio_i, sr_q};
  assign burst     = (cmd_addr_q == BURST_ADDR);
  assign last_byte = cmd_ram_q ? RAM_LAST : CLK_LAST;

  assign addr_o      = burst ? byte_q : cmd_addr_q;
  assign ram_o       = cmd_ram_q;
  assign burst_clk_o = burst & ~cmd_ram_q;
  assign data_o      = shift_in;
  assign wr_o        = ce_i & rise & (phase_q == PH_WR) & (bit_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      phase_q    <= PH_CMD;
      bit_q      <= '0;
      byte_q     <= '0;
      sr_q       <= '0;
      cmd_ram_q  <= 1'b0;
      cmd_addr_q <= '0;
      sdio_o     <= 1'b0;
      sdio_oe_o  <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (!ce_i) begin
        phase_q   <= PH_CMD;
        bit_q     <= '0;
        byte_q    <= '0;
        sdio_oe_o <= 1'b0;
      end else if (rise) begin
        sdio_oe_o <= 1'b0;
        sr_q      <= shift_in[7:1];
        case (phase_q)
          PH_CMD: begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              cmd_ram_q  <= shift_in[6];
              cmd_addr_q <= shift_in[ADDR_W:1];
              byte_q     <= '0;
              if (!shift_in[7])     phase_q <= PH_IDLE;
              else if (shift_in[0]) phase_q <= PH_RD;
              else                  phase_q <= PH_WR;
            end
          end
          PH_WR: begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              if (!burst || byte_q == last_byte) phase_q <= PH_IDLE;
              else byte_q <= byte_q + ADDR_W'(1);
            end
          end
          default: ;
        endcase
      end else if (fall && phase_q == PH_RD) begin
        sdio_o    <= rd_data_i[bit_q];
        sdio_oe_o <= 1'b1;
        bit_q     <= bit_q + 3'd1;
        if (bit_q == 3'd7 && burst)
          byte_q <= (byte_q == last_byte) ? '0 : byte_q + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/sio3_regs.sv
module sio3_regs
  import sio3_pkg::*;
#(
  parameter int CLK_REGS  = 8,
  parameter int RAM_BYTES = 31
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      wr_i,
  input  logic                      ram_i,
  input  logic                      burst_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [7:0]                data_i,
  output logic [7:0]                rd_data_o,
  output logic                      wp_o,
  output logic [(CLK_REGS-1)*8-1:0] time_o,
  output logic [RAM_BYTES*8-1:0]    ram_o
);
  localparam int TK_N = CLK_REGS - 1;
  localparam int IDX_W = $clog2(CLK_REGS);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CLK_REGS - 1);
  localparam logic [ADDR_W-1:0] RAM_N = ADDR_W'(RAM_BYTES);

  logic [7:0] tk_q    [TK_N];
  logic [7:0] stage_q [TK_N];
  logic [7:0] ram_q   [RAM_BYTES];
  logic       wp_q;
  logic [IDX_W-1:0] idx;

  assign idx  = addr_i[IDX_W-1:0];
  assign wp_o = wp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= 1'b0;
      for (int i = 0; i < TK_N; i++) begin
        tk_q[i]    <= '0;
        stage_q[i] <= '0;
      end
      for (int i = 0; i < RAM_BYTES; i++) ram_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < TK_N; i++) stage_q[i] <= '0;
    end else if (wr_i) begin
      if (ram_i) begin
        if (!wp_q && addr_i < RAM_N) ram_q[addr_i] <= data_i;
      end else if (burst_i) begin
        // eighth byte: commit the staged set, gated by protection held before it
        if (addr_i == CTL_A) begin
          wp_q <= data_i[7];
          if (!wp_q) for (int i = 0; i < TK_N; i++) tk_q[i] <= stage_q[i];
        end else if (addr_i < CTL_A) begin
          stage_q[idx] <= data_i;
        end
      end else if (addr_i == CTL_A) begin
        wp_q <= data_i[7];
      end else if (!wp_q && addr_i < CTL_A) begin
        tk_q[idx] <= data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (ram_i) begin
      if (addr_i < RAM_N) rd_data_o = ram_q[addr_i];
    end else if (addr_i < CTL_A) begin
      rd_data_o = tk_q[idx];
    end else if (addr_i == CTL_A) begin
      rd_data_o = {wp_q, 7'b0};
    end
  end

  for (genvar g = 0; g < TK_N; g++) begin : g_tk
    assign time_o[g*8 +: 8] = tk_q[g];
  end
  for (genvar g = 0; g < RAM_BYTES; g++) begin : g_ram
    assign ram_o[g*8 +: 8] = ram_q[g];
  end
endmodule

// File: rtl/sio3_slave.sv
module sio3_slave
  import sio3_pkg::*;
#(
  parameter int CLK_REGS  = 8,
  parameter int RAM_BYTES = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o
);
  logic              wr, ram, burst_clk, wp;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata, rd_data;
  logic [(CLK_REGS-1)*8-1:0] time_flat;
  logic [RAM_BYTES*8-1:0]    ram_flat;

  sio3_link #(.CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES)) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (ce_i),
    .sclk_i     (sclk_i),
    .sdio_i     (sdio_i),
    .sdio_o     (sdio_o),
    .sdio_oe_o  (sdio_oe_o),
    .wr_o       (wr),
    .ram_o      (ram),
    .burst_clk_o(burst_clk),
    .addr_o     (addr),
    .data_o     (wdata),
    .rd_data_i  (rd_data)
  );

  sio3_regs #(.CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (~ce_i),
    .wr_i     (wr),
    .ram_i    (ram),
    .burst_i  (burst_clk),
    .addr_i   (addr),
    .data_i   (wdata),
    .rd_data_o(rd_data),
    .wp_o     (wp),
    .time_o   (time_flat),
    .ram_o    (ram_flat)
  );
endmodule

// File: rtl/sio3_slave_chk.sv
module sio3_slave_chk #(
  parameter int CLK_REGS  = 8,
  parameter int RAM_BYTES = 31
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      ce_i,
  input logic                      sclk_i,
  input logic                      sdio_oe_o,
  input logic                      wp_i,
  input logic [(CLK_REGS-1)*8-1:0] time_i,
  input logic [RAM_BYTES*8-1:0]    ram_i
);
  logic sclk_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;

  // R3
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && sclk_i && !sclk_q) |=> !sdio_oe_o);

  // R2
  oe_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> ($past(sclk_q) && !$past(sclk_i)));

  // R10
  ce_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !sdio_oe_o);

  // R8
  wp_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> $stable(time_i));

  // R8
  wp_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> $stable(ram_i));
endmodule

bind sio3_slave sio3_slave_chk #(.CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_i     (ce_i),
  .sclk_i   (sclk_i),
  .sdio_oe_o(sdio_oe_o),
  .wp_i     (wp),
  .time_i   (time_flat),
  .ram_i    (ram_flat)
);

// File: tb/tb_sio3_slave.sv
`timescale 1ns/1ps
module tb_sio3_slave;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, soe;
  int checks = 0, errors = 0;
  bit done = 1'b0, settled = 1'b0;
  logic exp_oe = 1'b0, exp_bit = 1'b0;
  string cur_tag = "R13";

  logic [7:0] clk_m [7];
  logic [7:0] ram_m [31];
  logic       wp_m = 1'b0;
  logic [7:0] wq [$];

  always #10 clk = ~clk;

  sio3_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk),
    .sdio_i(sdi), .sdio_o(sdo), .sdio_oe_o(soe)
  );

  function automatic logic [7:0] m_read(bit ram, int a);
    if (ram) return (a < 31) ? ram_m[a] : 8'h00;
    if (a < 7) return clk_m[a];
    if (a == 7) return {wp_m, 7'b0};
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_byte(logic [7:0] cmd, int k);
    int a = int'(cmd[5:1]);
    if (a == 31) return m_read(cmd[6], k % (cmd[6] ? 31 : 8));
    return m_read(cmd[6], a);
  endfunction

  function automatic logic [7:0] mk(bit ram, int a, bit rd);
    logic [4:0] a5 = a[4:0];
    return {1'b1, ram, a5, rd};
  endfunction

  // per-clock comparison against the model expectation
  always @(negedge clk) begin
    if (settled && rst_n) begin
      checks++;
      if (soe !== exp_oe) begin
        errors++;
        $display("FAIL %s oe act %b exp %b at %0t", cur_tag, soe, exp_oe, $time);
      end
      if (exp_oe) begin
        checks++;
        if (sdo !== exp_bit) begin
          errors++;
          $display("FAIL %s data bit act %b exp %b at %0t", cur_tag, sdo, exp_bit, $time);
        end
      end
    end
  end

  task automatic xfer(input logic [7:0] cmd, input int ncyc);
    bit rd_ok = cmd[7] && cmd[0];
    logic [7:0] eb;
    int nb, a;
    @(negedge clk);
    ce = 1'b1;
    repeat (3) @(negedge clk);
    for (int n = 0; n < ncyc; n++) begin
      if (n < 8) sdi = cmd[n];
      else if ((n - 8) / 8 < wq.size()) sdi = wq[(n - 8) / 8][(n - 8) % 8];
      else sdi = 1'b0;
      settled = 1'b0; sclk = 1'b1; exp_oe = 1'b0;
      repeat (2) @(negedge clk);
      settled = 1'b1;
      repeat (2) @(negedge clk);
      settled = 1'b0; sclk = 1'b0;
      if (rd_ok && n >= 7) begin
        exp_oe = 1'b1;
        eb = exp_byte(cmd, (n - 7) / 8);
        exp_bit = eb[(n - 7) % 8];
      end
      repeat (2) @(negedge clk);
      settled = 1'b1;
      repeat (2) @(negedge clk);
    end
    settled = 1'b0; ce = 1'b0; exp_oe = 1'b0;
    repeat (2) @(negedge clk);
    settled = 1'b1;
    repeat (2) @(negedge clk);
    if (cmd[7] && !cmd[0]) begin
      nb = (ncyc < 8) ? 0 : (ncyc - 8) / 8;
      a = int'(cmd[5:1]);
      if (a == 31) begin
        if (cmd[6]) begin
          for (int i = 0; i < nb && i < 31; i++) if (!wp_m) ram_m[i] = wq[i];
        end else if (nb >= 8) begin
          if (!wp_m) for (int i = 0; i < 7; i++) clk_m[i] = wq[i];
          wp_m = wq[7][7];
        end
      end else if (nb >= 1) begin
        if (cmd[6]) begin
          if (!wp_m) ram_m[a] = wq[0];
        end else if (a == 7) wp_m = wq[0][7];
        else if (a < 7 && !wp_m) clk_m[a] = wq[0];
      end
    end
  endtask

  task automatic rd(input bit ram, input int a, input int nbytes);
    wq.delete();
    xfer(mk(ram, a, 1'b1), 8 + 8 * nbytes);
  endtask

  initial begin
    for (int i = 0; i < 7; i++) clk_m[i] = 8'h00;
    for (int i = 0; i < 31; i++) ram_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    settled = 1'b1;

    // R13: released pin and zeroed storage after reset
    cur_tag = "R13";
    checks++;
    if (soe !== 1'b0) begin errors++; $display("FAIL R13 oe act %b exp 0", soe); end
    rd(1'b0, 7, 1); rd(1'b0, 0, 1); rd(1'b1, 0, 1);

    // R1 R4: single write, extra byte ignored
    cur_tag = "R4";
    wq.delete(); wq.push_back(8'h5A); wq.push_back(8'hFF);
    xfer(mk(1'b0, 3, 1'b0), 24);
    cur_tag = "R1";  rd(1'b0, 3, 1);
    cur_tag = "R5";  rd(1'b0, 3, 3);
    cur_tag = "R2";  rd(1'b0, 2, 1);

    // R9: RAM burst write of four bytes, then reads
    cur_tag = "R9";
    wq.delete(); wq.push_back(8'h11); wq.push_back(8'h82); wq.push_back(8'h3C); wq.push_back(8'hE7);
    xfer(mk(1'b1, 31, 1'b0), 8 + 32);
    rd(1'b1, 2, 1); rd(1'b1, 4, 1);
    cur_tag = "R6";  rd(1'b1, 31, 33);
    wq.delete(); wq.push_back(8'hC3);
    xfer(mk(1'b1, 30, 1'b0), 16);
    rd(1'b1, 30, 1);

    // R7: partial clock burst changes nothing; full burst commits
    cur_tag = "R7";
    wq.delete();
    for (int i = 0; i < 8; i++) wq.push_back(8'(8'h20 + i * 3));
    wq[7] = 8'h00;
    xfer(mk(1'b0, 31, 1'b0), 8 + 40);
    rd(1'b0, 31, 9);
    xfer(mk(1'b0, 31, 1'b0), 8 + 64);
    cur_tag = "R6";  rd(1'b0, 31, 10);

    // R8: protection
    cur_tag = "R8";
    wq.delete(); wq.push_back(8'hFF);
    xfer(mk(1'b0, 7, 1'b0), 16);
    rd(1'b0, 7, 1);
    wq.delete(); wq.push_back(8'h99);
    xfer(mk(1'b0, 2, 1'b0), 16);
    xfer(mk(1'b1, 1, 1'b0), 16);
    wq.delete(); wq.push_back(8'h44); wq.push_back(8'h55);
    xfer(mk(1'b1, 31, 1'b0), 24);
    rd(1'b0, 31, 8); rd(1'b1, 31, 4);
    wq.delete();
    for (int i = 0; i < 8; i++) wq.push_back(8'(8'hA0 + i));
    wq[7] = 8'h7F;
    xfer(mk(1'b0, 31, 1'b0), 8 + 64);
    rd(1'b0, 31, 8);
    wq.delete(); wq.push_back(8'h66);
    xfer(mk(1'b0, 2, 1'b0), 16);
    rd(1'b0, 2, 1);

    // R11: no storage in clock addresses 8..30
    cur_tag = "R11";
    wq.delete(); wq.push_back(8'h77);
    xfer(mk(1'b0, 12, 1'b0), 16);
    rd(1'b0, 12, 2); rd(1'b0, 8, 1);

    // R12: commands without the valid marker
    cur_tag = "R12";
    wq.delete(); wq.push_back(8'h99);
    xfer(8'h00, 24);
    xfer(8'h01, 32);
    rd(1'b0, 0, 1);

    // R10: chip enable drop mid-command and mid-read
    cur_tag = "R10";
    wq.delete(); wq.push_back(8'hFF);
    xfer(mk(1'b0, 0, 1'b0), 4);
    rd(1'b0, 0, 1);
    wq.delete();
    xfer(mk(1'b0, 1, 1'b1), 13);
    checks++;
    if (soe !== 1'b0) begin errors++; $display("FAIL R10 oe act %b exp 0", soe); end
    rd(1'b0, 1, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule